// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides where each of the two ALU operands of the instruction in the execute stage of a five-stage pipeline should come from. It compares the two source register indices of that instruction with the destination indices of the two older instructions that are still in flight: the one in the memory stage and the one in the write-back stage. An older instruction counts only if it will write a register. From these comparisons the block produces one 2-bit select per operand.

The selects drive operand multiplexers that sit outside the block. Those multiplexers pick the register-file read value, the ALU result held in the memory stage, or the value being written back. A dependent instruction can therefore use a result as soon as it has been computed, without waiting for the register-file write. The block has no storage and produces its selects combinationally from the current indices.

Top module: `exe_bypass_sel`

## Requirements
- R1: When the memory-stage instruction writes a register, its destination index is nonzero and it equals the execute-stage first source index, `sel_a` is 2'b10.
- R2: When the memory-stage instruction writes a register, its destination index is nonzero and it equals the execute-stage second source index, `sel_b` is 2'b10.
- R3: When the write-back-stage instruction writes a register, its destination index is nonzero and it equals the first source index, and R1 does not apply, `sel_a` is 2'b01.
- R4: When the write-back-stage instruction writes a register, its destination index is nonzero and it equals the second source index, and R2 does not apply, `sel_b` is 2'b01.
- R5: A destination index of 0 never causes a bypass. A source index of 0 always gives select 2'b00, because register 0 always reads as zero.
- R6: A stage whose write-enable is low never causes a bypass, even when its destination index matches.
- R7: When both older stages match the same source index, the memory-stage result wins and the select is 2'b10.
- R8: When neither stage matches a source index, that operand's select is 2'b00, meaning it comes from the register file.
- R9: The two operands are resolved independently, so each operand can take a different source in the same cycle.
- R10: The select value 2'b11 never appears on either operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | REG_W | First source register index of the execute-stage instruction |
| ex_rt | input | REG_W | Second source register index of the execute-stage instruction |
| mem_wen | input | 1 | High when the memory-stage instruction writes a register |
| mem_dst | input | REG_W | Destination register index of the memory-stage instruction |
| wb_wen | input | 1 | High when the write-back-stage instruction writes a register |
| wb_dst | input | REG_W | Destination register index of the write-back-stage instruction |
| sel_a | output | 2 | Source select for the first operand: 00 register file, 10 memory stage, 01 write-back |
| sel_b | output | 2 | Source select for the second operand, with the same encoding |

## Verification
The bench builds the block with the default 5-bit register index, so all 32 register numbers can be reached, including index 0 and the highest index 31. The vector table covers each source of each operand on its own, gated write-enables, register 0 used as source and as destination, both stages hitting the same index, and the two operands resolving to different sources in the same cycle. A sweep over every index then puts both stages on the same register as the first source. This checks the memory-stage priority and the register-0 exclusion across the whole index range, and that select 11 never appears.

// File: rtl/exe_bypass_sel.sv
module exe_bypass_sel #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] ex_rs,
  input  logic [REG_W-1:0] ex_rt,
  input  logic             mem_wen,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             wb_wen,
  input  logic [REG_W-1:0] wb_dst,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b
);

  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic mem_live, wb_live;
  assign mem_live = mem_wen && (mem_dst != ZERO_REG);
  assign wb_live  = wb_wen  && (wb_dst  != ZERO_REG);

  logic [1:0] mem_hit, wb_hit;
  logic [REG_W-1:0] src [2];
  logic [1:0] sel [2];
  assign src[0] = ex_rs;
  assign src[1] = ex_rt;

  for (genvar i = 0; i < 2; i++) begin : g_opnd
    assign mem_hit[i] = mem_live && (mem_dst == src[i]);
    assign wb_hit[i]  = wb_live  && (wb_dst  == src[i]);
    assign sel[i] = mem_hit[i] ? SEL_MEM : (wb_hit[i] ? SEL_WB : SEL_RF);
  end

  assign sel_a = sel[0];
  assign sel_b = sel[1];

  always_comb begin
    AST_NO_ILLEGAL_A: assert (sel_a != 2'b11); // R10
    AST_NO_ILLEGAL_B: assert (sel_b != 2'b11); // R10
    AST_ZERO_SRC_A: assert (ex_rs != ZERO_REG || sel_a == SEL_RF); // R5
    AST_ZERO_SRC_B: assert (ex_rt != ZERO_REG || sel_b == SEL_RF); // R5
    AST_MEM_NEEDS_WEN: assert (!(sel_a == SEL_MEM || sel_b == SEL_MEM) || mem_wen); // R6
    AST_WB_NEEDS_WEN: assert (!(sel_a == SEL_WB || sel_b == SEL_WB) || wb_wen); // R6
    AST_WB_A_MATCH: assert (sel_a != SEL_WB || (wb_dst == ex_rs && mem_dst != ex_rs) || (wb_dst == ex_rs && !mem_wen)); // R3
    AST_MEM_A_MATCH: assert (sel_a != SEL_MEM || mem_dst == ex_rs); // R1
    AST_MEM_B_MATCH: assert (sel_b != SEL_MEM || mem_dst == ex_rt); // R2
    AST_WB_B_MATCH: assert (sel_b != SEL_WB || wb_dst == ex_rt); // R4
  end

endmodule

// File: tb/exe_bypass_sel_tb.sv
module exe_bypass_sel_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [4:0] ex_rs, ex_rt, mem_dst, wb_dst;
  logic mem_wen, wb_wen;
  logic [1:0] sel_a, sel_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  exe_bypass_sel #(.REG_W(5)) u_dut (
    .ex_rs(ex_rs), .ex_rt(ex_rt),
    .mem_wen(mem_wen), .mem_dst(mem_dst),
    .wb_wen(wb_wen), .wb_dst(wb_dst),
    .sel_a(sel_a), .sel_b(sel_b)
  );

  // {rs, rt, mem_wen, mem_dst, wb_wen, wb_dst, exp_a, exp_b}
  localparam int NV = 12;
  localparam logic [25:0] VEC [NV] = '{
    {5'd3,  5'd4,  1'b1, 5'd3,  1'b0, 5'd0,  2'b10, 2'b00}, // R1
    {5'd3,  5'd4,  1'b1, 5'd4,  1'b0, 5'd0,  2'b00, 2'b10}, // R2
    {5'd7,  5'd8,  1'b0, 5'd0,  1'b1, 5'd7,  2'b01, 2'b00}, // R3
    {5'd7,  5'd8,  1'b0, 5'd0,  1'b1, 5'd8,  2'b00, 2'b01}, // R4
    {5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  2'b00, 2'b00}, // R5
    {5'd5,  5'd5,  1'b0, 5'd5,  1'b0, 5'd5,  2'b00, 2'b00}, // R6
    {5'd9,  5'd9,  1'b1, 5'd9,  1'b1, 5'd9,  2'b10, 2'b10}, // R7
    {5'd1,  5'd2,  1'b1, 5'd3,  1'b1, 5'd4,  2'b00, 2'b00}, // R8
    {5'd10, 5'd11, 1'b1, 5'd11, 1'b1, 5'd10, 2'b01, 2'b10}, // R9
    {5'd31, 5'd31, 1'b1, 5'd31, 1'b0, 5'd0,  2'b10, 2'b10}, // R1
    {5'd6,  5'd12, 1'b1, 5'd6,  1'b1, 5'd12, 2'b10, 2'b01}, // R9
    {5'd0,  5'd15, 1'b1, 5'd0,  1'b1, 5'd15, 2'b00, 2'b01}  // R5
  };
  string tags [NV] = '{"R1","R2","R3","R4","R5","R6","R7","R8","R9","R1","R9","R5"};

  task automatic check(input string tag, input logic [1:0] ea, input logic [1:0] eb);
    checks++;
    if (sel_a !== ea || sel_b !== eb) begin
      errors++;
      $display("FAIL %s: sel_a=%b sel_b=%b expected sel_a=%b sel_b=%b", tag, sel_a, sel_b, ea, eb);
    end
  endtask

  task automatic drive(input logic [25:0] v);
    @(negedge clk);
    {ex_rs, ex_rt, mem_wen, mem_dst, wb_wen, wb_dst} = v[25:4];
    #2;
  endtask

  initial begin
    {ex_rs, ex_rt, mem_wen, mem_dst, wb_wen, wb_dst} = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset idle", 2'b00, 2'b00);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      check(tags[i], VEC[i][3:2], VEC[i][1:0]);
    end

    // R7 / R5 / R10 sweep: both stages write rs, rt is a distinct index
    for (int r = 0; r < 32; r++) begin
      drive({5'(r), 5'(31 - r), 1'b1, 5'(r), 1'b1, 5'(r), 4'b0000});
      check(r == 0 ? "R5 sweep" : "R7 sweep", (r != 0) ? 2'b10 : 2'b00, 2'b00);
      checks++;
      if (sel_a == 2'b11 || sel_b == 2'b11) begin
        errors++;
        $display("FAIL R10: sel_a=%b sel_b=%b expected neither 11", sel_a, sel_b);
      end
    end

    // R6: write-back gated off while memory stage also gated off
    drive({5'd20, 5'd21, 1'b0, 5'd20, 1'b0, 5'd21, 4'b0000});
    check("R6 both gated", 2'b00, 2'b00);
    // R3: memory stage writes an unrelated register, write-back supplies rs
    drive({5'd14, 5'd2, 1'b1, 5'd13, 1'b1, 5'd14, 4'b0000});
    check("R3 wb behind unrelated mem", 2'b01, 2'b00);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule